// File: doc/BRIEF.md
# Two-Level Write-Back Cache Controller

This block is a two-level data cache hierarchy that sits between a processor load/store port and a line-oriented main-memory port. The near level is small and direct-mapped. It takes its set index from the virtual address and keeps the full physical line address as its tag. The far level has four times as many lines of the same size and is indexed and tagged with the physical address. For this cacheable window, the physical address is the virtual address with its top bits removed. No translation step is involved.

Misses are handled strictly one level at a time. A line read from memory lands only in the far level. The near level is always refilled from the far level, and the original request is then replayed against the near level. Stores are captured in a one-entry store buffer and merged into the cached line under a byte mask. Modified lines go down one level only when they are evicted. A dirty near-level victim moves into the far level, and a dirty far-level victim is written to memory. A flush request pushes every dirty line in both levels out to memory and leaves both levels empty.

The processor accepts one request at a time and raises a one-cycle done pulse when that request finishes.

Top module: `wb_cache_hier`

## Requirements
- R1: After reset, cpu_ready is high, cpu_done and mem_valid are low, and every line in both levels is invalid, so the first access to any line reads that line from memory.
- R2: The physical address is the low PA_W bits of the virtual address (12 of 16 by default). Two virtual addresses that differ only in the dropped top bits read and write the same data, and the second access needs no memory traffic.
- R3: A read that misses in both levels makes exactly one memory line read of LINE_WORDS beats at the requested physical line address (physical address bits 11:4) and no memory write. The read then returns the memory word.
- R4: A read of a line held in the near level completes with no memory transfer and returns the cached word.
- R5: A store goes through the store buffer and replaces only the bytes whose cpu_be bit is set (bit i covers data bits 8i+7:8i). It causes no memory write while the line stays cached.
- R6: When a dirty near-level line is displaced, its data moves into the far level and not into memory. A later read of that line is served from the far level with no memory transfer and returns the stored data.
- R7: When a dirty far-level line is displaced, it is written to memory as a full line before the new line is read. Memory then holds the stored data.
- R8: Each accepted request produces exactly one one-cycle cpu_done pulse. cpu_ready stays low from acceptance until that pulse.
- R9: A memory beat moves only when mem_valid and mem_ready are both high. While mem_ready is low, mem_valid, mem_we, mem_addr and mem_wdata hold steady. Results are correct for any number of wait cycles per beat.
- R10: A flush pulse, taken while idle, writes every dirty line of both levels to memory and invalidates both levels, then pulses flush_done once. Afterwards memory equals a model of all completed stores, and the next access to a line reads it from memory again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request accepted this cycle when high with cpu_valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | VA_W | Virtual byte address (word aligned) |
| cpu_wdata | input | WORD_W | Store data |
| cpu_be | input | WORD_W/8 | Store byte mask |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Load data, valid with cpu_done for loads |
| flush | input | 1 | Write back and invalidate both levels |
| flush_done | output | 1 | One-cycle pulse when the flush has finished |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory beat accept |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | PA_W-log2(line bytes) | Physical line address |
| mem_wdata | output | WORD_W | Write beat data |
| mem_rdata | input | WORD_W | Read beat data, valid with mem_ready |

## Verification
Several access patterns are applied, each chosen to reach a different path. Repeated reads within one line separate a near-level hit from a miss. Virtual aliases that differ only in the dropped top bits show that the physical tag is what decides a hit. Two addresses that collide in the near level but not in the far level show that a dirty victim moves down one level and not out to memory. Addresses 1 KiB apart collide in both levels and force a far-level write-back ahead of the refill. Memory latency is varied from zero to several wait cycles per beat, and the bench counts memory line reads and writes per access to tell each path apart. A final flush is compared word by word against a reference model of all stores.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_NEAR, ST_VICT, ST_FAR, ST_WBK, ST_MRD, ST_FLN, ST_FLF
  } cst_e;

  typedef enum logic [1:0] {RT_VICT, RT_MRD, RT_FLF} ret_e;
endpackage

// File: rtl/dm_level.sv
module dm_level #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 8,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINES-1:0]  dirty_vec
);
  logic [LINES-1:0]  vld_q, drt_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINE_W-1:0] dat_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= wr_valid;
      drt_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid  = vld_q[rd_idx];
  assign rd_dirty  = drt_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_line   = dat_q[rd_idx];
  assign dirty_vec = drt_q;

  assert_dirty_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drt_q & ~vld_q) == '0);
endmodule

// File: rtl/store_slot.sv
module store_slot #(
  parameter int VA_W       = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int BE_W   = WORD_W / 8,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int BOFF_W = $clog2(BE_W),
  localparam int WSEL_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drain,
  input  logic              in_we,
  input  logic [VA_W-1:0]   in_addr,
  input  logic [WORD_W-1:0] in_wdata,
  input  logic [BE_W-1:0]   in_be,
  output logic              q_we,
  output logic [VA_W-1:0]   q_addr,
  input  logic [LINE_W-1:0] line_in,
  output logic [LINE_W-1:0] line_merged,
  output logic [WORD_W-1:0] word_out
);
  logic              full_q, full_d;
  logic [WORD_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic [WSEL_W-1:0] wsel;

  always_comb begin
    full_d = full_q;
    if (load)  full_d = 1'b1;
    if (drain) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_we    <= in_we;
      q_addr  <= in_addr;
      wdata_q <= in_wdata;
      be_q    <= in_be;
    end
  end

  assign wsel     = q_addr[BOFF_W +: WSEL_W];
  assign word_out = line_in[wsel*WORD_W +: WORD_W];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign line_merged[w*WORD_W + b*8 +: 8] =
        (wsel == WSEL_W'(w) && be_q[b]) ? wdata_q[b*8 +: 8] : line_in[w*WORD_W + b*8 +: 8];
    end
  end

  assert_slot_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full_q);
  assert_drain_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> full_q);
endmodule

// File: rtl/wb_cache_hier.sv
module wb_cache_hier
  import wb_cache_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NEAR_LINES = 16,
  parameter int FAR_LINES  = 64,
  localparam int BE_W   = WORD_W / 8,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int OFF_W  = $clog2(LINE_WORDS * BE_W),
  localparam int LA_W   = PA_W - OFF_W,
  localparam int NI_W   = $clog2(NEAR_LINES),
  localparam int FI_W   = $clog2(FAR_LINES),
  localparam int FT_W   = LA_W - FI_W,
  localparam int BEAT_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [VA_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic              flush,
  output logic              flush_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [LA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  cst_e st_q, st_d;
  ret_e ret_q, ret_d;
  logic [FI_W-1:0]   fidx_q, fidx_d, fi_q, fi_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [LINE_W-1:0] lbuf_q, lbuf_d;
  logic              flushing_q, flushing_d, done_q, done_d, fdone_q, fdone_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;

  logic              sb_load, sb_drain, q_we;
  logic [VA_W-1:0]   q_addr;
  logic [LINE_W-1:0] merged;
  logic [WORD_W-1:0] hit_word;
  logic [LA_W-1:0]   req_la;
  logic [NI_W-1:0]   req_ni, n_ridx;
  logic [FI_W-1:0]   req_fi, f_ridx;
  logic [FT_W-1:0]   req_ft;

  logic n_v, n_d, n_we, n_wv, n_wd;
  logic [LA_W-1:0]   n_tag, n_wtag;
  logic [LINE_W-1:0] n_line, n_wline;
  logic [NEAR_LINES-1:0] n_dvec;
  logic f_v, f_d, f_we, f_wv, f_wd;
  logic [FT_W-1:0]   f_tag, f_wtag;
  logic [LINE_W-1:0] f_line, f_wline;
  logic [FI_W-1:0]   f_widx;
  logic [FAR_LINES-1:0] f_dvec;
  logic beat_fire, last_beat;
  logic unused_addr;

  store_slot #(.VA_W(VA_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) i_slot (
    .clk, .rst_n, .load(sb_load), .drain(sb_drain), .in_we(cpu_we), .in_addr(cpu_addr),
    .in_wdata(cpu_wdata), .in_be(cpu_be), .q_we, .q_addr, .line_in(n_line),
    .line_merged(merged), .word_out(hit_word));

  assign req_la = q_addr[PA_W-1:OFF_W];
  assign req_ni = q_addr[OFF_W +: NI_W];
  assign req_fi = req_la[FI_W-1:0];
  assign req_ft = req_la[LA_W-1:FI_W];
  assign unused_addr = ^{q_addr[VA_W-1:PA_W], q_addr[OFF_W-BEAT_W-1:0]};

  assign n_ridx = flushing_q ? fidx_q[NI_W-1:0] : req_ni;
  assign f_ridx = (st_q == ST_FLF) ? fidx_q : fi_q;

  dm_level #(.LINES(NEAR_LINES), .TAG_W(LA_W), .LINE_W(LINE_W)) i_near (
    .clk, .rst_n, .rd_idx(n_ridx), .rd_valid(n_v), .rd_dirty(n_d), .rd_tag(n_tag),
    .rd_line(n_line), .wr_en(n_we), .wr_idx(n_ridx), .wr_valid(n_wv), .wr_dirty(n_wd),
    .wr_tag(n_wtag), .wr_line(n_wline), .dirty_vec(n_dvec));

  dm_level #(.LINES(FAR_LINES), .TAG_W(FT_W), .LINE_W(LINE_W)) i_far (
    .clk, .rst_n, .rd_idx(f_ridx), .rd_valid(f_v), .rd_dirty(f_d), .rd_tag(f_tag),
    .rd_line(f_line), .wr_en(f_we), .wr_idx(f_widx), .wr_valid(f_wv), .wr_dirty(f_wd),
    .wr_tag(f_wtag), .wr_line(f_wline), .dirty_vec(f_dvec));

  assign mem_valid = (st_q == ST_WBK) || (st_q == ST_MRD);
  assign mem_we    = (st_q == ST_WBK);
  assign mem_addr  = mem_we ? {f_tag, fi_q} : req_la;
  assign mem_wdata = f_line[beat_q*WORD_W +: WORD_W];
  assign beat_fire = mem_valid && mem_ready;
  assign last_beat = (beat_q == BEAT_W'(LINE_WORDS - 1));
  assign cpu_ready = (st_q == ST_IDLE) && !flush;

  always_comb begin
    st_d = st_q; ret_d = ret_q; fidx_d = fidx_q; fi_d = fi_q; beat_d = beat_q;
    lbuf_d = lbuf_q; flushing_d = flushing_q; rdata_d = rdata_q;
    done_d = 1'b0; fdone_d = 1'b0; sb_load = 1'b0; sb_drain = 1'b0;
    n_we = 1'b0; n_wv = 1'b0; n_wd = 1'b0; n_wtag = req_la; n_wline = f_line;
    f_we = 1'b0; f_wv = 1'b0; f_wd = 1'b0; f_wtag = req_ft; f_wline = lbuf_q; f_widx = fi_q;
    unique case (st_q)
      ST_IDLE: begin
        if (flush) begin
          flushing_d = 1'b1; fidx_d = '0; st_d = ST_FLN;
        end else if (cpu_valid) begin
          sb_load = 1'b1; st_d = ST_NEAR;
        end
      end
      ST_NEAR: begin
        if (n_v && n_tag == req_la) begin
          done_d = 1'b1; rdata_d = hit_word; sb_drain = 1'b1; st_d = ST_IDLE;
          if (q_we) begin
            n_we = 1'b1; n_wv = 1'b1; n_wd = 1'b1; n_wline = merged;
          end
        end else if (n_v && n_d) begin
          fi_d = n_tag[FI_W-1:0]; st_d = ST_VICT;
        end else begin
          fi_d = req_fi; st_d = ST_FAR;
        end
      end
      ST_VICT: begin
        if (f_v && f_d && f_tag != n_tag[LA_W-1:FI_W]) begin
          ret_d = RT_VICT; beat_d = '0; st_d = ST_WBK;
        end else begin
          f_we = 1'b1; f_wv = 1'b1; f_wd = 1'b1; f_wtag = n_tag[LA_W-1:FI_W]; f_wline = n_line;
          n_we = 1'b1;
          if (flushing_q) st_d = ST_FLN;
          else begin fi_d = req_fi; st_d = ST_FAR; end
        end
      end
      ST_FAR: begin
        beat_d = '0;
        if (f_v && f_tag == req_ft) begin
          n_we = 1'b1; n_wv = 1'b1; st_d = ST_NEAR;
        end else if (f_v && f_d) begin
          ret_d = RT_MRD; st_d = ST_WBK;
        end else st_d = ST_MRD;
      end
      ST_WBK: begin
        if (beat_fire) begin
          beat_d = beat_q + BEAT_W'(1);
          if (last_beat) begin
            f_we = 1'b1;
            st_d = (ret_q == RT_VICT) ? ST_VICT : (ret_q == RT_FLF) ? ST_FLF : ST_MRD;
          end
        end
      end
      ST_MRD: begin
        if (beat_fire) begin
          lbuf_d[beat_q*WORD_W +: WORD_W] = mem_rdata;
          beat_d = beat_q + BEAT_W'(1);
          if (last_beat) begin
            f_we = 1'b1; f_wv = 1'b1; f_wline = lbuf_d; st_d = ST_FAR;
          end
        end
      end
      ST_FLN: begin
        if (n_v && n_d) begin
          fi_d = n_tag[FI_W-1:0]; st_d = ST_VICT;
        end else begin
          n_we = 1'b1;
          if (fidx_q == FI_W'(NEAR_LINES - 1)) begin fidx_d = '0; st_d = ST_FLF; end
          else fidx_d = fidx_q + FI_W'(1);
        end
      end
      ST_FLF: begin
        if (f_v && f_d) begin
          fi_d = fidx_q; ret_d = RT_FLF; beat_d = '0; st_d = ST_WBK;
        end else begin
          f_we = 1'b1; f_widx = fidx_q;
          if (fidx_q == FI_W'(FAR_LINES - 1)) begin
            fidx_d = '0; flushing_d = 1'b0; fdone_d = 1'b1; st_d = ST_IDLE;
          end else fidx_d = fidx_q + FI_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ret_q <= RT_MRD; fidx_q <= '0; fi_q <= '0; beat_q <= '0;
      flushing_q <= 1'b0; done_q <= 1'b0; fdone_q <= 1'b0; rdata_q <= '0;
    end else begin
      st_q <= st_d; ret_q <= ret_d; fidx_q <= fidx_d; fi_q <= fi_d; beat_q <= beat_d;
      flushing_q <= flushing_d; done_q <= done_d; fdone_q <= fdone_d;
      if (done_d) rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_MRD && beat_fire) lbuf_q <= lbuf_d;
  end

  assign cpu_done   = done_q;
  assign cpu_rdata  = rdata_q;
  assign flush_done = fdone_q;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready) |=> !cpu_ready);
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));
  assert_flush_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (n_dvec == '0 && f_dvec == '0));
  assert_no_mem_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !mem_valid);
endmodule

// File: tb/test_wb_cache_hier.sv
module test_wb_cache_hier;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 150000;

  logic        clk, rst_n;
  logic        cpu_valid, cpu_ready, cpu_we, cpu_done;
  logic [15:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic [3:0]  cpu_be;
  logic        flush, flush_done;
  logic        mem_valid, mem_ready, mem_we;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem   [1024];
  logic [31:0] refm  [1024];
  int n_chk, n_fail, cyc, lat, wcnt, rd_lines, wr_lines;
  logic [1:0] bbeat;

  wb_cache_hier i_wb_cache_hier (
    .clk, .rst_n, .cpu_valid, .cpu_ready, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_be,
    .cpu_done, .cpu_rdata, .flush, .flush_done, .mem_valid, .mem_ready, .mem_we,
    .mem_addr, .mem_wdata, .mem_rdata);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: cycles=%0d expected<=%0d", cyc, MAX_CYC);
      summary();
    end
  end

  // memory model: one beat granted per ready pulse after lat wait cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0; wcnt = 0; bbeat = '0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_valid) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0; mem_ready = 1'b1;
        if (mem_we) mem[{mem_addr, bbeat}] = mem_wdata;
        else        mem_rdata = mem[{mem_addr, bbeat}];
        if (bbeat == 2'd3) begin
          if (mem_we) wr_lines++; else rd_lines++;
        end
        bbeat = bbeat + 2'd1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    while (!cpu_done) @(negedge clk);
    rd = cpu_rdata;
    if (we) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) refm[a[11:2]][b*8 +: 8] = d[b*8 +: 8];
    end
  endtask

  task automatic rd_check(input logic [15:0] a, input int exp_rd, input int exp_wr, input string req);
    int r0, w0;
    logic [31:0] v;
    r0 = rd_lines; w0 = wr_lines;
    access(1'b0, a, '0, '0, v);
    chk(v == refm[a[11:2]], req, v, refm[a[11:2]]);
    chk(rd_lines - r0 == exp_rd, {req, " line reads"}, rd_lines - r0, exp_rd);
    chk(wr_lines - w0 == exp_wr, {req, " line writes"}, wr_lines - w0, exp_wr);
  endtask

  task automatic st_check(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be,
                          input int exp_rd, input string req);
    int r0, w0;
    logic [31:0] v;
    r0 = rd_lines; w0 = wr_lines;
    access(1'b1, a, d, be, v);
    chk(rd_lines - r0 == exp_rd, {req, " line reads"}, rd_lines - r0, exp_rd);
    chk(wr_lines == w0, {req, " no memory write"}, wr_lines - w0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
    chk(cpu_done == 1'b0 && mem_valid == 1'b0, "R1 idle outputs", {cpu_done, mem_valid}, 0);
    rd_check(16'h0010, 1, 0, "R1 R3 first read misses");
  endtask

  task automatic t_hit_alias();
    rd_check(16'h0014, 0, 0, "R4 near hit");
    rd_check(16'hF014, 0, 0, "R2 alias read");
    st_check(16'h0018, 32'hDEAD_BEEF, 4'b0101, 0, "R5 masked store");
    rd_check(16'h0018, 0, 0, "R5 merged readback");
    st_check(16'hA01C, 32'h1234_5678, 4'b1110, 0, "R2 alias store");
    rd_check(16'h001C, 0, 0, "R2 alias store readback");
  endtask

  task automatic t_near_evict();
    st_check(16'h0000, 32'hCAFE_F00D, 4'b1111, 1, "R6 store new line");
    rd_check(16'h0100, 1, 0, "R6 near conflict");
    rd_check(16'h0000, 0, 0, "R6 served by far level");
  endtask

  task automatic t_far_evict();
    rd_check(16'h0400, 1, 1, "R7 far conflict");
    for (int i = 0; i < 4; i++)
      chk(mem[i] == refm[i], "R7 memory holds victim", mem[i], refm[i]);
  endtask

  task automatic t_latency();
    lat = 0;
    rd_check(16'h0C40, 1, 0, "R9 zero wait");
    lat = 4;
    rd_check(16'h0D58, 1, 0, "R9 long wait");
    lat = 2;
  endtask

  task automatic t_flush();
    int w0, bad;
    st_check(16'h0024, 32'h0BAD_F00D, 4'b0011, 1, "R10 store line2");
    st_check(16'h0830, 32'h7777_0001, 4'b1000, 1, "R10 store line3");
    w0 = wr_lines;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    while (!flush_done) @(negedge clk);
    chk(wr_lines - w0 == 3, "R10 dirty lines written", wr_lines - w0, 3);
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refm[i]) bad++;
    chk(bad == 0, "R10 memory matches model", bad, 0);
    rd_check(16'h0018, 1, 0, "R10 invalidated");
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; lat = 2; rd_lines = 0; wr_lines = 0;
    cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    flush = 1'b0; mem_ready = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 32'h5A00_0000 + i * 32'h0001_0203;
      refm[i] = 32'h5A00_0000 + i * 32'h0001_0203;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit_alias();
    t_near_evict();
    t_far_evict();
    t_latency();
    t_flush();
    summary();
  end
endmodule